// File: doc/BRIEF.md
# Exception Entry State Update Unit

This block works out how processor state changes when an interrupt exception is taken. Each cycle it samples the current program counter, the current status word, two configuration bits and a pair of request lines, one for a normal interrupt and one for a fast interrupt. One clock later it presents four registered results: the return link, the saved copy of the status word, the rewritten status word and the vector address to fetch next. A valid flag marks the cycles in which an exception entry was computed.

The status rewrite takes the same shape for both exception kinds. It forces the instruction-set state bit to the fixed-width encoding. It disables further normal interrupts and imprecise aborts. It loads the exception endianness from configuration. It then writes a mode code that differs between the two kinds. A fast-interrupt entry also masks further fast interrupts. The vector is either a low or a high table entry, chosen by the high-vectors configuration bit. Register banking, pipeline flushing and choosing among interrupt sources are handled elsewhere.

Top module: `excEntryUnit`

## Requirements
- R1: While `rstN` is low, `linkOut`, `savedPsrOut`, `newPsrOut` and `newPcOut` are all zero and `entryValid` is low.
- R2: One cycle after a request, `linkOut` equals the sampled `curPc` plus 4, modulo 2^32.
- R3: One cycle after a request, `savedPsrOut` equals the sampled `curPsr` with no bit changed.
- R4: On either exception kind, `newPsrOut` has bit 5 cleared and bits 7 and 8 set.
- R5: On either exception kind, `newPsrOut` bit 9 equals the sampled `endianCfg`.
- R6: On a normal interrupt entry (`takeIrq` high, `takeFiq` low), `newPsrOut[4:0]` is 5'b10010 and bit 6 keeps its sampled value.
- R7: On a fast interrupt entry, `newPsrOut[4:0]` is 5'b10001 and bit 6 is set.
- R8: A normal interrupt entry gives `newPcOut` = 32'h0000_0018, or 32'hFFFF_0018 when `highVec` is high.
- R9: A fast interrupt entry gives `newPcOut` = 32'h0000_001C, or 32'hFFFF_001C when `highVec` is high.
- R10: When `takeIrq` and `takeFiq` are both high, the entry is a fast interrupt entry (R7, R9 apply).
- R11: With neither request high, the next cycle shows `entryValid` low, `newPcOut` and `linkOut` equal to the sampled `curPc`, and `newPsrOut` and `savedPsrOut` equal to the sampled `curPsr`.
- R12: On an entry, `newPsrOut[31:10]` equals the sampled `curPsr[31:10]`.
- R13: `entryValid` is high exactly in the cycle after one in which at least one request was sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| curPc | input | 32 | Current program counter |
| curPsr | input | 32 | Current status word |
| endianCfg | input | 1 | Endianness to use on exception entry |
| highVec | input | 1 | Selects the high vector table |
| takeIrq | input | 1 | Request to take a normal interrupt |
| takeFiq | input | 1 | Request to take a fast interrupt |
| linkOut | output | 32 | Return link value |
| savedPsrOut | output | 32 | Copy of the status word before the update |
| newPsrOut | output | 32 | Updated status word |
| newPcOut | output | 32 | Next program counter (vector address) |
| entryValid | output | 1 | High when the outputs hold an exception entry |

## Verification
The bench sends both request lines high together. A design that ranked the normal interrupt first would return mode 10010 and a vector ending in 18 instead of 1C. It uses a program counter of 32'hFFFF_FFFC to check that the link wraps to zero, and it uses status words with bit 6 clear and bit 5 set to show that a normal entry leaves the fast-interrupt mask alone while still clearing the state bit. Idle cycles with arbitrary inputs check that nothing is rewritten without a request. A design that let the mode or vector logic act in idle cycles would corrupt the pass-through values.

// File: rtl/excEntryPkg.sv
package excEntryPkg;

  localparam int unsigned WORD_W = 32;

  // Status word bit positions whose behaviour is fixed by the entry rules.
  localparam int unsigned MODE_LO   = 0;
  localparam int unsigned MODE_W    = 5;
  localparam int unsigned BIT_STATE = 5;
  localparam int unsigned BIT_FMASK = 6;
  localparam int unsigned BIT_IMASK = 7;
  localparam int unsigned BIT_AMASK = 8;
  localparam int unsigned BIT_ENDIAN = 9;

  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;

  // Strobes passed from control to datapath.
  typedef struct packed {
    logic enter;   // an exception entry happens this cycle
    logic fiqSel;  // entry is of the fast kind
  } entryStrobe_t;

endpackage

// File: rtl/excEntryCtrl.sv
module excEntryCtrl
  import excEntryPkg::*;
(
  input  logic         takeIrq,
  input  logic         takeFiq,
  output entryStrobe_t strobe
);

  // Fast request dominates; either request starts an entry.
  always_comb begin
    strobe        = '0;
    strobe.enter  = takeIrq | takeFiq;
    strobe.fiqSel = takeFiq;
  end

endmodule

// File: rtl/excEntryData.sv
module excEntryData
  import excEntryPkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned PSR_W       = 32,
  parameter int unsigned LINK_STEP   = 4,
  parameter logic [31:0] LOW_BASE    = 32'h0000_0000,
  parameter logic [31:0] HIGH_BASE   = 32'hFFFF_0000,
  parameter logic [7:0]  IRQ_OFFSET  = 8'h18,
  parameter logic [7:0]  FIQ_OFFSET  = 8'h1C
)(
  input  logic              clk,
  input  logic              rstN,
  input  entryStrobe_t      strobe,
  input  logic [ADDR_W-1:0] curPc,
  input  logic [PSR_W-1:0]  curPsr,
  input  logic              endianCfg,
  input  logic              highVec,
  output logic [ADDR_W-1:0] linkOut,
  output logic [PSR_W-1:0]  savedPsrOut,
  output logic [PSR_W-1:0]  newPsrOut,
  output logic [ADDR_W-1:0] newPcOut,
  output logic              entryValid
);

  localparam logic [ADDR_W-1:0] STEP_EXT  = ADDR_W'(LINK_STEP);
  localparam logic [ADDR_W-1:0] LOW_EXT   = ADDR_W'(LOW_BASE);
  localparam logic [ADDR_W-1:0] HIGH_EXT  = ADDR_W'(HIGH_BASE);
  localparam logic [ADDR_W-1:0] IRQ_EXT   = ADDR_W'(IRQ_OFFSET);
  localparam logic [ADDR_W-1:0] FIQ_EXT   = ADDR_W'(FIQ_OFFSET);

  logic [ADDR_W-1:0] linkNext;
  logic [ADDR_W-1:0] vecBase;
  logic [ADDR_W-1:0] vecAddr;
  logic [ADDR_W-1:0] pcNext;
  logic [PSR_W-1:0]  psrNext;

  // Return link: incremented address on entry, plain copy when idle.
  always_comb begin
    linkNext = strobe.enter ? (curPc + STEP_EXT) : curPc;
  end

  // Vector address selection.
  always_comb begin
    vecBase = highVec ? HIGH_EXT : LOW_EXT;
    vecAddr = vecBase | (strobe.fiqSel ? FIQ_EXT : IRQ_EXT);
    pcNext  = strobe.enter ? vecAddr : curPc;
  end

  // Status rewrite; untouched bits fall through from curPsr.
  always_comb begin
    psrNext = curPsr;
    if (strobe.enter) begin
      psrNext[BIT_STATE]  = 1'b0;
      psrNext[BIT_IMASK]  = 1'b1;
      psrNext[BIT_AMASK]  = 1'b1;
      psrNext[BIT_ENDIAN] = endianCfg;
      if (strobe.fiqSel) begin
        psrNext[MODE_LO +: MODE_W] = MODE_FIQ;
        psrNext[BIT_FMASK]         = 1'b1;
      end else begin
        psrNext[MODE_LO +: MODE_W] = MODE_IRQ;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      linkOut     <= '0;
      savedPsrOut <= '0;
      newPsrOut   <= '0;
      newPcOut    <= '0;
      entryValid  <= 1'b0;
    end else begin
      linkOut     <= linkNext;
      savedPsrOut <= curPsr;
      newPsrOut   <= psrNext;
      newPcOut    <= pcNext;
      entryValid  <= strobe.enter;
    end
  end

  // Marks that the outputs were loaded at least once since reset.
  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  a_r2_link_step: assert property (@(posedge clk) disable iff (!rstN)
    (armed && entryValid) |-> (linkOut == $past(curPc) + STEP_EXT));

  a_r3_saved_copy: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (savedPsrOut == $past(curPsr)));

  a_r4_fixed_bits: assert property (@(posedge clk) disable iff (!rstN)
    (armed && entryValid) |->
      (!newPsrOut[BIT_STATE] && newPsrOut[BIT_IMASK] && newPsrOut[BIT_AMASK]));

  a_r5_endian: assert property (@(posedge clk) disable iff (!rstN)
    (armed && entryValid) |-> (newPsrOut[BIT_ENDIAN] == $past(endianCfg)));

  a_r7_fiq_mode: assert property (@(posedge clk) disable iff (!rstN)
    (armed && entryValid && $past(strobe.fiqSel)) |->
      (newPsrOut[MODE_LO +: MODE_W] == MODE_FIQ && newPsrOut[BIT_FMASK]));

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !entryValid) |->
      (newPcOut == $past(curPc) && newPsrOut == $past(curPsr)));

  a_r12_upper_pass: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (newPsrOut[PSR_W-1:BIT_ENDIAN+1] == $past(curPsr[PSR_W-1:BIT_ENDIAN+1])));

  a_r13_valid_timing: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (entryValid == ($past(takeAny))));

  logic takeAny;
  assign takeAny = strobe.enter;

endmodule

// File: rtl/excEntryUnit.sv
module excEntryUnit
  import excEntryPkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PSR_W  = 32
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] curPc,
  input  logic [PSR_W-1:0]  curPsr,
  input  logic              endianCfg,
  input  logic              highVec,
  input  logic              takeIrq,
  input  logic              takeFiq,
  output logic [ADDR_W-1:0] linkOut,
  output logic [PSR_W-1:0]  savedPsrOut,
  output logic [PSR_W-1:0]  newPsrOut,
  output logic [ADDR_W-1:0] newPcOut,
  output logic              entryValid
);

  entryStrobe_t strobe;

  excEntryCtrl u_ctrl (
    .takeIrq (takeIrq),
    .takeFiq (takeFiq),
    .strobe  (strobe)
  );

  excEntryData #(
    .ADDR_W (ADDR_W),
    .PSR_W  (PSR_W)
  ) u_data (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .curPc       (curPc),
    .curPsr      (curPsr),
    .endianCfg   (endianCfg),
    .highVec     (highVec),
    .linkOut     (linkOut),
    .savedPsrOut (savedPsrOut),
    .newPsrOut   (newPsrOut),
    .newPcOut    (newPcOut),
    .entryValid  (entryValid)
  );

  // R10: a cycle with both requests is treated as a fast entry.
  a_r10_fiq_priority: assert property (@(posedge clk) disable iff (!rstN)
    (takeIrq && takeFiq) |=> (!rstN || newPcOut[7:0] == 8'h1C));

endmodule

// File: tb/excEntryUnit_bench.sv
module excEntryUnit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] curPc = '0;
  logic [31:0] curPsr = '0;
  logic        endianCfg = 1'b0;
  logic        highVec = 1'b0;
  logic        takeIrq = 1'b0;
  logic        takeFiq = 1'b0;
  logic [31:0] linkOut, savedPsrOut, newPsrOut, newPcOut;
  logic        entryValid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  excEntryUnit u_excEntryUnit (
    .clk(clk), .rstN(rstN), .curPc(curPc), .curPsr(curPsr),
    .endianCfg(endianCfg), .highVec(highVec), .takeIrq(takeIrq), .takeFiq(takeFiq),
    .linkOut(linkOut), .savedPsrOut(savedPsrOut), .newPsrOut(newPsrOut),
    .newPcOut(newPcOut), .entryValid(entryValid)
  );

  // Vector: {pc, psr, endian, highVec, irq, fiq}
  localparam int NV = 10;
  localparam logic [67:0] VECS [NV] = '{
    {32'h0000_1000, 32'h0000_0010, 1'b0, 1'b0, 1'b1, 1'b0},
    {32'h8000_0040, 32'hF000_00FF, 1'b1, 1'b1, 1'b1, 1'b0},
    {32'h1234_5678, 32'h0000_0020, 1'b1, 1'b0, 1'b0, 1'b1},
    {32'hABCD_0000, 32'hA5A5_0013, 1'b0, 1'b1, 1'b0, 1'b1},
    {32'h0000_2000, 32'h0000_0000, 1'b1, 1'b0, 1'b1, 1'b1},
    {32'h0000_3000, 32'h5555_5555, 1'b0, 1'b1, 1'b1, 1'b1},
    {32'h0000_4000, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0, 1'b0},
    {32'hDEAD_BEE0, 32'h0000_0220, 1'b0, 1'b0, 1'b1, 1'b0},
    {32'h7FFF_FFFC, 32'hFFFF_FDBF, 1'b0, 1'b1, 1'b1, 1'b0},
    {32'h0F0F_0F0C, 32'h3C3C_3C3C, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one set of inputs after a falling edge, check after the next falling edge.
  task automatic runVec(input logic [31:0] pc, input logic [31:0] psr, input logic en,
                        input logic hv, input logic irq, input logic fiq);
    logic [31:0] expPsr, expPc;
    bit take, fast;
    take = irq | fiq;
    fast = fiq;
    curPc = pc; curPsr = psr; endianCfg = en; highVec = hv;
    takeIrq = irq; takeFiq = fiq;
    @(negedge clk);
    expPsr = psr;
    if (take) begin
      expPsr[5] = 1'b0; expPsr[7] = 1'b1; expPsr[8] = 1'b1; expPsr[9] = en;
      if (fast) begin expPsr[4:0] = 5'b10001; expPsr[6] = 1'b1; end
      else      expPsr[4:0] = 5'b10010;
      expPc = (hv ? 32'hFFFF_0000 : 32'h0) | (fast ? 32'h1C : 32'h18);
      check("R13 valid", {31'b0, entryValid}, 32'd1);
      check("R2 link", linkOut, pc + 32'd4);
      check("R3 saved", savedPsrOut, psr);
      check("R4 fixed bits", {29'b0, newPsrOut[8], newPsrOut[7], newPsrOut[5]},
            {29'b0, expPsr[8], expPsr[7], expPsr[5]});
      check("R5 endian", {31'b0, newPsrOut[9]}, {31'b0, en});
      check("R12 upper", {10'b0, newPsrOut[31:10]}, {10'b0, psr[31:10]});
      if (irq && fiq) begin
        check("R10 mode", {26'b0, newPsrOut[6:0] & 7'h5F}, {26'b0, expPsr[6:0] & 7'h5F});
        check("R10 vector", newPcOut, expPc);
      end else if (fast) begin
        check("R7 mode", {26'b0, newPsrOut[6], newPsrOut[4:0]}, {26'b0, expPsr[6], expPsr[4:0]});
        check("R9 vector", newPcOut, expPc);
      end else begin
        check("R6 mode", {26'b0, newPsrOut[6], newPsrOut[4:0]}, {26'b0, expPsr[6], expPsr[4:0]});
        check("R8 vector", newPcOut, expPc);
      end
    end else begin
      check("R11 valid", {31'b0, entryValid}, 32'd0);
      check("R11 pc", newPcOut, pc);
      check("R11 link", linkOut, pc);
      check("R11 psr", newPsrOut, psr);
      check("R11 saved", savedPsrOut, psr);
    end
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    curPc = 32'hFFFF_FFFF; curPsr = 32'hFFFF_FFFF; takeIrq = 1'b1; takeFiq = 1'b1;
    @(negedge clk);
    // R1: reset holds outputs at zero despite active inputs.
    check("R1 link", linkOut, 32'h0);
    check("R1 saved", savedPsrOut, 32'h0);
    check("R1 psr", newPsrOut, 32'h0);
    check("R1 pc", newPcOut, 32'h0);
    check("R1 valid", {31'b0, entryValid}, 32'h0);
    rstN = 1'b1;
    takeIrq = 1'b0; takeFiq = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      runVec(VECS[i][67:36], VECS[i][35:4], VECS[i][3], VECS[i][2], VECS[i][1], VECS[i][0]);
    end

    // R2: link wraps at the top of the address space.
    runVec(32'hFFFF_FFFC, 32'h0000_0013, 1'b0, 1'b0, 1'b1, 1'b0);
    // R6: normal entry keeps a clear fast mask clear, clears state bit.
    runVec(32'h0000_0100, 32'h0000_02A0, 1'b1, 1'b1, 1'b1, 1'b0);
    // R13: back-to-back entry then idle drops valid.
    runVec(32'h0000_0200, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b1);
    runVec(32'h0000_0300, 32'h0000_0033, 1'b0, 1'b1, 1'b0, 1'b0);
    // R10: both requests with high vectors.
    runVec(32'h0000_0400, 32'h0000_0012, 1'b1, 1'b1, 1'b1, 1'b1);

    // R1: reset in the middle of a run clears everything.
    takeFiq = 1'b1;
    rstN = 1'b0;
    #1;
    check("R1 midrun pc", newPcOut, 32'h0);
    check("R1 midrun valid", {31'b0, entryValid}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    takeFiq = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule